// File: doc/BRIEF.md
# DRAM Idle Low-Power State Controller

This block runs in the DFI clock domain, which runs at half the DRAM clock. It counts how long the memory bus has been idle and, as that idle time grows, asks the memory controller to move the DRAM into deeper low-power states. There are five programmable idle limits. Two of them, the power-down limit and the standby limit, are counted in plain DFI cycles. The other three, the self-refresh limit, the self-refresh-with-controller-gating limit and the LPDDR4-only self-refresh power-down lite limit, are counted in units of 1024 DFI cycles. Each state drives its own set of requests: power-down, self-refresh and SR-PD lite. Each state also drives its own set of clock-gate enables for the controller clock, the PHY-interface clock, the PHY clock and the DRAM clock.

When the bus becomes busy during a low-power state, the block enters an exit state. In that state it drops every request and every clock gate and raises an exit request. It waits there until the memory side reports that the exit is complete, and only then returns to active. Limits are written through a simple write port into staging registers. They are copied into the working set only while the block is active, so the working limits never change in the middle of a low-power episode. An auto-power-down enable input lets software block the shallow power-down state, for example when the memory clock runs at a high frequency.

Top module: `dram_idle_pwr_ctrl`

## Requirements
- R1: With auto-power-down enabled and a non-zero power-down limit N, the block raises `pd_req` and enters state 1 on the clock edge after the counter reaches N consecutive idle DFI cycles. That is edge N+1 counted from the first idle edge.
- R2: With a non-zero self-refresh limit S, the block raises `sr_req` and enters state 2 on the edge after S*1024 idle cycles. A limit of 0 disables its state.
- R3: With a non-zero gating limit G, the block enters state 3 on the edge after G*1024 idle cycles. In state 3 it drives `sr_req` and `gate_ctrl_clk` high.
- R4: The lite state (state 4) asserts `srpd_lite_req`, `sr_req` and `gate_ctrl_clk`. It is entered on the edge after L*1024 idle cycles, but only when `mem_type` is 2 (LPDDR4). The other encodings are 0 for DDR3 and 1 for LPDDR3, and with either of them the lite limit is ignored.
- R5: With a non-zero standby limit T, the block enters state 5 on the edge after T idle cycles, counted in raw DFI cycles. In state 5 it drives `sr_req`, `gate_ctrl_clk`, `gate_phy_if_clk`, `gate_phy_clk` and `gate_dram_clk` high.
- R6: `lp_state` encodes the states as 0 active, 1 power-down, 2 self-refresh, 3 self-refresh with gating, 4 lite, 5 standby and 6 exit. The deepest enabled state whose limit has been reached wins. While the bus stays idle, `lp_state` never moves to a shallower state.
- R7: A busy cycle in states 1 to 5 moves the block to state 6 on the next edge. In state 6 `exit_req` is high and all requests and gates are low. The block stays in state 6 until `exit_done` is sampled high, then returns to state 0. The busy cycle also clears the idle count.
- R8: When `auto_pd_en` is low, state 1 is never entered. The deeper states are not affected.
- R9: The idle counter saturates at its maximum value. A held idle period keeps the block in the state it has reached.
- R10: A write with `cfg_we` high stores `cfg_val` into the staging register selected by `cfg_idx`: 0 power-down, 1 self-refresh, 2 gating, 3 lite, 4 standby. An index above 4 is ignored. Staged values take effect only while the block is in state 0.
- R11: After reset all limits are 0, `lp_state` is 0 and all outputs are low. An idle bus then causes no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_busy | input | 1 | High in any cycle with a bus request |
| mem_type | input | 2 | DRAM type: 0 DDR3, 1 LPDDR3, 2 LPDDR4 |
| auto_pd_en | input | 1 | Allows the power-down state |
| cfg_we | input | 1 | Limit write strobe |
| cfg_idx | input | 3 | Limit select |
| cfg_val | input | TH_W | Limit value |
| exit_done | input | 1 | Memory side finished the low-power exit |
| pd_req | output | 1 | Power-down request |
| sr_req | output | 1 | Self-refresh request |
| srpd_lite_req | output | 1 | Self-refresh power-down lite request |
| exit_req | output | 1 | Exit-low-power request |
| gate_ctrl_clk | output | 1 | Gate the controller clock |
| gate_phy_if_clk | output | 1 | Gate the PHY-interface clock |
| gate_phy_clk | output | 1 | Gate the PHY clock |
| gate_dram_clk | output | 1 | Gate the DRAM clock |
| lp_state | output | 3 | Current state code |

## Verification
The hardest situation to reach from the ports is counter saturation. With the default limit width, the counter spans tens of millions of idle cycles. To reach it, the bench adds a second instance with a 4-bit limit width, which gives a 14-bit counter. It then holds the bus idle for longer than 16383 cycles while the self-refresh limit sits close to the ceiling. The staging rule is also awkward to hit. The bench writes a limit that the running count has already passed while the block sits in power-down, shows that the state does not move, and then shows that the new limit acts after an exit.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

  typedef enum logic [2:0] {
    LP_ACTIVE = 3'd0,
    LP_PD     = 3'd1,
    LP_SR     = 3'd2,
    LP_SRG    = 3'd3,
    LP_LITE   = 3'd4,
    LP_STBY   = 3'd5,
    LP_EXIT   = 3'd6
  } lp_state_e;

  typedef enum logic [1:0] {
    MEM_DDR3   = 2'd0,
    MEM_LPDDR3 = 2'd1,
    MEM_LPDDR4 = 2'd2
  } mem_type_e;

  localparam int NUM_TH  = 5;
  localparam int TH_PD   = 0;
  localparam int TH_SR   = 1;
  localparam int TH_SRG  = 2;
  localparam int TH_LITE = 3;
  localparam int TH_STBY = 4;

  // limits counted in units of 2**SCALE_SHIFT cycles
  localparam logic [NUM_TH-1:0] TH_SCALED = 5'b01110;

  typedef struct packed {
    logic pd;
    logic sr;
    logic lite;
    logic ex;
    logic g_ctrl;
    logic g_phy_if;
    logic g_phy;
    logic g_dram;
  } lp_ctl_t;

endpackage

// File: rtl/dlp_cfg_regs.sv
module dlp_cfg_regs
  import dlp_pkg::*;
#(
  parameter int TH_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_idx,
  input  logic [TH_W-1:0]               cfg_val,
  input  logic                          in_active,
  output logic [NUM_TH-1:0][TH_W-1:0]   live_th
);

  logic [NUM_TH-1:0][TH_W-1:0] staged_th;

  for (genvar i = 0; i < NUM_TH; i++) begin : g_th
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged_th[i] <= '0;
      end else if (cfg_we && (cfg_idx == 3'(i))) begin
        staged_th[i] <= cfg_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_th[i] <= '0;
      end else if (in_active) begin
        live_th[i] <= staged_th[i];
      end
    end
  end

  // R10: working limits frozen outside the active state
  p_live_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_active |=> $stable(live_th));

endmodule

// File: rtl/dlp_idle_timer.sv
module dlp_idle_timer
  import dlp_pkg::*;
#(
  parameter int TH_W        = 16,
  parameter int SCALE_SHIFT = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_busy,
  input  logic                          hold_clr,
  input  logic [NUM_TH-1:0][TH_W-1:0]   live_th,
  output logic [NUM_TH-1:0]             hit
);

  localparam int CNT_W = TH_W + SCALE_SHIFT;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] idle_cnt;
  logic             clr;

  assign clr = bus_busy || hold_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (clr) begin
      idle_cnt <= '0;
    end else if (idle_cnt != CNT_MAX) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_TH; i++) begin : g_cmp
    logic [CNT_W-1:0] lim;
    if (TH_SCALED[i]) begin : g_scaled
      assign lim = {live_th[i], {SCALE_SHIFT{1'b0}}};
    end else begin : g_raw
      assign lim = {{SCALE_SHIFT{1'b0}}, live_th[i]};
    end
    assign hit[i] = (live_th[i] != '0) && (idle_cnt >= lim);
  end

  // R9: saturating count
  p_cnt_hold_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == CNT_MAX && !clr) |=> idle_cnt == CNT_MAX);
  p_cnt_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt != '0 && !clr) |=> idle_cnt != '0);
  // R7: busy clears the count
  p_busy_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> idle_cnt == '0);

endmodule

// File: rtl/dlp_state_seq.sv
module dlp_state_seq
  import dlp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_busy,
  input  logic              exit_done,
  input  logic              auto_pd_en,
  input  mem_type_e         mem_type,
  input  logic [NUM_TH-1:0] hit,
  output lp_state_e         state
);

  lp_state_e tgt;
  lp_state_e nxt;

  always_comb begin
    if (hit[TH_STBY])                             tgt = LP_STBY;
    else if (hit[TH_LITE] && mem_type == MEM_LPDDR4) tgt = LP_LITE;
    else if (hit[TH_SRG])                         tgt = LP_SRG;
    else if (hit[TH_SR])                          tgt = LP_SR;
    else if (hit[TH_PD] && auto_pd_en)            tgt = LP_PD;
    else                                          tgt = LP_ACTIVE;
  end

  always_comb begin
    nxt = state;
    if (state == LP_EXIT) begin
      if (exit_done) nxt = LP_ACTIVE;
    end else if (bus_busy) begin
      nxt = (state == LP_ACTIVE) ? LP_ACTIVE : LP_EXIT;
    end else if (tgt > state) begin
      nxt = tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LP_ACTIVE;
    else        state <= nxt;
  end

  // R6: no retreat while idle
  p_no_shallower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LP_EXIT && !bus_busy) |=> state >= $past(state));
  // R7: busy during low power leads to exit
  p_busy_to_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LP_ACTIVE && state != LP_EXIT && bus_busy) |=> state == LP_EXIT);
  p_exit_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_EXIT && !exit_done) |=> state == LP_EXIT);
  // R4: lite entered only for LPDDR4
  p_lite_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LP_LITE) ##1 (state == LP_LITE) |-> $past(mem_type) == MEM_LPDDR4);
  // R8: power-down blocked
  p_pd_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_ACTIVE && !auto_pd_en) |=> state != LP_PD);

endmodule

// File: rtl/dlp_out_decode.sv
module dlp_out_decode
  import dlp_pkg::*;
(
  input  lp_state_e state,
  output lp_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    unique case (state)
      LP_PD:   ctl.pd = 1'b1;
      LP_SR:   ctl.sr = 1'b1;
      LP_SRG: begin
        ctl.sr     = 1'b1;
        ctl.g_ctrl = 1'b1;
      end
      LP_LITE: begin
        ctl.sr     = 1'b1;
        ctl.lite   = 1'b1;
        ctl.g_ctrl = 1'b1;
      end
      LP_STBY: begin
        ctl.sr       = 1'b1;
        ctl.g_ctrl   = 1'b1;
        ctl.g_phy_if = 1'b1;
        ctl.g_phy    = 1'b1;
        ctl.g_dram   = 1'b1;
      end
      LP_EXIT: ctl.ex = 1'b1;
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/dram_idle_pwr_ctrl.sv
module dram_idle_pwr_ctrl
  import dlp_pkg::*;
#(
  parameter int TH_W        = 16,
  parameter int SCALE_SHIFT = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_busy,
  input  logic [1:0]      mem_type,
  input  logic            auto_pd_en,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_idx,
  input  logic [TH_W-1:0] cfg_val,
  input  logic            exit_done,
  output logic            pd_req,
  output logic            sr_req,
  output logic            srpd_lite_req,
  output logic            exit_req,
  output logic            gate_ctrl_clk,
  output logic            gate_phy_if_clk,
  output logic            gate_phy_clk,
  output logic            gate_dram_clk,
  output logic [2:0]      lp_state
);

  logic [NUM_TH-1:0][TH_W-1:0] live_th;
  logic [NUM_TH-1:0]           hit;
  lp_state_e                   state;
  lp_ctl_t                     ctl;
  mem_type_e                   mtype;

  assign mtype = mem_type_e'(mem_type);

  dlp_cfg_regs #(.TH_W(TH_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_val   (cfg_val),
    .in_active (state == LP_ACTIVE),
    .live_th   (live_th)
  );

  dlp_idle_timer #(.TH_W(TH_W), .SCALE_SHIFT(SCALE_SHIFT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_busy (bus_busy),
    .hold_clr (state == LP_EXIT),
    .live_th  (live_th),
    .hit      (hit)
  );

  dlp_state_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_busy   (bus_busy),
    .exit_done  (exit_done),
    .auto_pd_en (auto_pd_en),
    .mem_type   (mtype),
    .hit        (hit),
    .state      (state)
  );

  dlp_out_decode u_dec (
    .state (state),
    .ctl   (ctl)
  );

  assign pd_req          = ctl.pd;
  assign sr_req          = ctl.sr;
  assign srpd_lite_req   = ctl.lite;
  assign exit_req        = ctl.ex;
  assign gate_ctrl_clk   = ctl.g_ctrl;
  assign gate_phy_if_clk = ctl.g_phy_if;
  assign gate_phy_clk    = ctl.g_phy;
  assign gate_dram_clk   = ctl.g_dram;
  assign lp_state        = state;

  // R7: clock gates released the cycle after a busy request in low power
  p_gates_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && lp_state != 3'd0 && lp_state != 3'd6) |=>
      !(gate_ctrl_clk || gate_phy_if_clk || gate_phy_clk || gate_dram_clk) && exit_req);
  // R5: DRAM clock gating comes only with the full standby set
  p_stby_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_dram_clk |-> (gate_phy_clk && gate_phy_if_clk && gate_ctrl_clk && sr_req));
  // R7: exit request never overlaps a state request
  p_exit_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> !(pd_req || sr_req || srpd_lite_req));

endmodule

// File: tb/dram_idle_pwr_ctrl_bench.sv
module dram_idle_pwr_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_busy = 1'b1;
  logic [1:0]  mem_type = 2'd0;
  logic        auto_pd_en = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [15:0] cfg_val = 16'd0;
  logic        exit_done = 1'b0;

  logic pd_req, sr_req, lite_req, exit_req, g_ctrl, g_phy_if, g_phy, g_dram;
  logic [2:0] lp_state;
  logic s_pd, s_sr, s_lite, s_ex, s_gc, s_gi, s_gp, s_gd;
  logic [2:0] s_state;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dram_idle_pwr_ctrl u_dram_idle_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .mem_type(mem_type),
    .auto_pd_en(auto_pd_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
    .exit_done(exit_done), .pd_req(pd_req), .sr_req(sr_req), .srpd_lite_req(lite_req),
    .exit_req(exit_req), .gate_ctrl_clk(g_ctrl), .gate_phy_if_clk(g_phy_if),
    .gate_phy_clk(g_phy), .gate_dram_clk(g_dram), .lp_state(lp_state)
  );

  dram_idle_pwr_ctrl #(.TH_W(4), .SCALE_SHIFT(10)) u_small (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .mem_type(mem_type),
    .auto_pd_en(auto_pd_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val[3:0]),
    .exit_done(exit_done), .pd_req(s_pd), .sr_req(s_sr), .srpd_lite_req(s_lite),
    .exit_req(s_ex), .gate_ctrl_clk(s_gc), .gate_phy_if_clk(s_gi),
    .gate_phy_clk(s_gp), .gate_dram_clk(s_gd), .lp_state(s_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gates();
    return {28'd0, g_ctrl, g_phy_if, g_phy, g_dram};
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_val = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic go_active();
    @(negedge clk);
    bus_busy = 1'b1;
    edges(1);
    if (lp_state == 3'd6) begin
      exit_done = 1'b1;
      @(negedge clk);
      exit_done = 1'b0;
    end
    edges(1);
  endtask

  task automatic set_all(input int pd, input int sr, input int srg, input int lt, input int sb);
    wr(0, pd); wr(1, sr); wr(2, srg); wr(3, lt); wr(4, sb);
    edges(2);
  endtask

  task automatic release_bus();
    @(negedge clk);
    bus_busy = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 state", lp_state, 0);
    chk("R11 reqs", {pd_req, sr_req, lite_req, exit_req}, 0);
    chk("R11 gates", gates(), 0);
    release_bus();
    edges(300);
    chk("R11 idle stays active", lp_state, 0);
  endtask

  task automatic t_pd_and_exit();
    go_active();
    set_all(10, 0, 0, 0, 0);
    release_bus();
    edges(10);
    chk("R1 before limit", pd_req, 0);
    edges(1);
    chk("R1 pd_req", pd_req, 1);
    chk("R1 state", lp_state, 1);
    bus_busy = 1'b1;
    edges(1);
    chk("R7 exit state", lp_state, 6);
    chk("R7 exit_req", exit_req, 1);
    chk("R7 pd dropped", pd_req, 0);
    edges(5);
    chk("R7 waits for exit_done", lp_state, 6);
    exit_done = 1'b1;
    edges(1);
    exit_done = 1'b0;
    chk("R7 back to active", lp_state, 0);
    release_bus();
    edges(10);
    chk("R7 count restarted", pd_req, 0);
    edges(1);
    chk("R7 re-entry at limit", pd_req, 1);
  endtask

  task automatic t_sr_chain();
    go_active();
    set_all(10, 1, 2, 0, 0);
    release_bus();
    edges(11);
    chk("R6 first pd", lp_state, 1);
    edges(1013);
    chk("R2 before 1024", sr_req, 0);
    edges(1);
    chk("R2 sr_req", sr_req, 1);
    chk("R2 state", lp_state, 2);
    chk("R2 no gate", g_ctrl, 0);
    edges(1023);
    chk("R3 before 2048", g_ctrl, 0);
    edges(1);
    chk("R3 state", lp_state, 3);
    chk("R3 sr and gate", {sr_req, g_ctrl}, 3);
  endtask

  task automatic t_lite();
    go_active();
    mem_type = 2'd0;
    set_all(0, 0, 2, 3, 0);
    release_bus();
    edges(3200);
    chk("R4 DDR3 ignores lite", lp_state, 3);
    chk("R4 no lite req", lite_req, 0);
    go_active();
    mem_type = 2'd2;
    release_bus();
    edges(3072);
    chk("R4 before lite limit", lp_state, 3);
    edges(1);
    chk("R4 lite state", lp_state, 4);
    chk("R4 lite outputs", {lite_req, sr_req, g_ctrl}, 7);
    mem_type = 2'd0;
  endtask

  task automatic t_stby();
    go_active();
    set_all(0, 1, 0, 0, 5000);
    release_bus();
    edges(5000);
    chk("R5 before limit", lp_state, 2);
    edges(1);
    chk("R5 standby", lp_state, 5);
    chk("R5 gates", gates(), 15);
    chk("R5 sr", sr_req, 1);
    bus_busy = 1'b1;
    edges(1);
    chk("R7 gates off after request", gates(), 0);
    chk("R7 exit_req", exit_req, 1);
  endtask

  task automatic t_deep_first();
    go_active();
    set_all(10, 1, 0, 0, 20);
    release_bus();
    edges(11);
    chk("R6 pd first", lp_state, 1);
    edges(10);
    chk("R6 standby", lp_state, 5);
    edges(1100);
    chk("R6 no shallower after sr limit", lp_state, 5);
  endtask

  task automatic t_autopd();
    go_active();
    auto_pd_en = 1'b0;
    set_all(10, 1, 0, 0, 0);
    release_bus();
    edges(200);
    chk("R8 pd blocked", lp_state, 0);
    chk("R8 pd_req low", pd_req, 0);
    edges(825);
    chk("R8 sr unaffected", lp_state, 2);
    auto_pd_en = 1'b1;
  endtask

  task automatic t_cfg();
    go_active();
    set_all(10, 0, 0, 0, 0);
    release_bus();
    edges(1100);
    chk("R10 in pd", lp_state, 1);
    wr(1, 1);
    wr(7, 1);
    edges(100);
    chk("R10 staged not used", lp_state, 1);
    go_active();
    release_bus();
    edges(1025);
    chk("R10 applied after active", lp_state, 2);
  endtask

  task automatic t_sat();
    go_active();
    set_all(0, 15, 0, 0, 0);
    release_bus();
    edges(15360);
    chk("R9 small before limit", s_state, 0);
    edges(1);
    chk("R9 small sr", s_state, 2);
    edges(2000);
    chk("R9 held past counter max", s_state, 2);
    chk("R9 sr_req held", s_sr, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(2);
    t_reset();
    t_pd_and_exit();
    t_sr_chain();
    t_lite();
    t_stby();
    t_deep_first();
    t_autopd();
    t_cfg();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule